// File: doc/BRIEF.md
# Low-Power State Sequencer

This block decides when a small processor core may stop its clock and how it comes back. Software writes a 16-bit control word that holds a mode select, a standby wake-qualification length and a watchdog-wake enable. Writing the mode does nothing by itself. Only when the core pulses its idle-instruction strobe does the sequencer read the mode held at that instant and move into IDLE, STANDBY or HALT. In every one of those states the CPU clock enable is low.

Each state has its own wake rule. IDLE leaves on any enabled interrupt. STANDBY leaves on a selected GPIO wake pin that is held low for a programmable number of cycles, or on a watchdog interrupt that both enables allow. HALT turns the oscillator off. It then comes back in order: a selected wake pin pulled low starts the oscillator, a stable oscillator starts PLL locking, and a locked PLL re-enables the clock. The oscillator and the PLL appear only as request outputs and ready inputs. HALT is refused while the clock is in missing-clock (limp) operation. In that case the sequencer drops to IDLE and sets a sticky error flag.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` is 0x0000, `lpm_state` is 0 (run), and `cpu_clk_en`, `osc_pwr_req` and `pll_lock_req` are 1. `wake_irq` and `halt_err` are 0.
- R2: `cfg_rdata` returns bit 15 = watchdog-wake enable, bits 7..2 = qualification length Q, and bits 1..0 = mode. Bits 14..8 always read 0, whatever was written.
- R3: A write to the mode field leaves the state and the clock enable unchanged. On `idle_strobe` in run, the mode value decides the next state: 00 = IDLE (`lpm_state` 1), 01 = STANDBY (`lpm_state` 2), 10 or 11 = HALT with the oscillator off (`lpm_state` 4).
- R4: In IDLE, `cpu_clk_en` is 0. If `irq_any` is sampled high at an edge, then after that edge the state is run and `cpu_clk_en` is 1.
- R5: In STANDBY, a wake pin selected by `gpio_sel` wakes the block once it has been held low for Q+2 consecutive cycles after a two-flop synchronizer (2 cycles for Q=0, 65 cycles for Q=63). A shorter low pulse does not wake it. A high level restarts the count.
- R6: Pins whose `gpio_sel` bit is 0 never wake the block. Low levels outside STANDBY do not count toward qualification.
- R7: In STANDBY, `wd_irq` wakes the block on the next edge only when the watchdog-wake enable bit and `wd_irq_en` are both 1.
- R8: In HALT, `osc_pwr_req` and `pll_lock_req` are 0. A synchronized low on a selected pin moves the block to the oscillator phase (`lpm_state` 5, `osc_pwr_req` 1). `osc_stable` then moves it to the PLL phase (`lpm_state` 6, `pll_lock_req` 1). `pll_locked` then returns it to run.
- R9: If the selected wake pins all go high again while the block is in the oscillator phase, the block returns to the oscillator-off state (`lpm_state` 4).
- R10: A HALT request while `limp_status` is 1 enters IDLE instead and sets `halt_err`. The flag stays set until `err_clr` is pulsed.
- R11: `wake_irq` is high for exactly one cycle, in the first run cycle after any exit from a low-power state, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read-back |
| idle_strobe | input | 1 | Core executed its idle instruction |
| irq_any | input | 1 | Any enabled interrupt pending |
| wd_irq | input | 1 | Watchdog interrupt |
| wd_irq_en | input | 1 | Watchdog's own interrupt enable |
| limp_status | input | 1 | Clock is running in missing-clock mode |
| err_clr | input | 1 | Clears the HALT-refused flag |
| gpio_wake_n | input | NPIN | Active-low wake pins (asynchronous) |
| gpio_sel | input | NPIN | Per-pin wake select mask |
| osc_stable | input | 1 | Oscillator reports stable |
| pll_locked | input | 1 | PLL reports lock |
| osc_pwr_req | output | 1 | Request oscillator power |
| pll_lock_req | output | 1 | Request PLL locking |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| wake_irq | output | 1 | One-cycle wake interrupt |
| halt_err | output | 1 | Sticky flag: HALT refused in limp mode |
| lpm_state | output | 3 | Current state code |

## Verification
The assertions check the rules that hold on every cycle. Without a write, the control word keeps its value. An interrupt in IDLE reopens the clock on the next cycle. A limp-mode HALT request always lands in IDLE with the error flag set. The PLL request only rises after the oscillator has reported stable. The wake interrupt never lasts two cycles. Qualification is cleared whenever the block is outside STANDBY. Only the bench scenarios show the exact qualification boundary (Q+2 versus Q+1 low cycles at the extremes and at random values), the abort of a HALT exit and its restart, and that deselected pins and half-enabled watchdogs stay ignored.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int CFG_W  = 16;
    localparam int QUAL_W = 6;
    localparam int MODE_W = 2;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_IDLE = 3'd1,
        ST_STBY = 3'd2,
        ST_HOFF = 3'd4,
        ST_HOSC = 3'd5,
        ST_HPLL = 3'd6
    } lpm_state_e;

    localparam logic [MODE_W-1:0] MODE_IDLE = 2'b00;
    localparam logic [MODE_W-1:0] MODE_STBY = 2'b01;

    typedef struct packed {
        logic              wd_wake_en;
        logic [QUAL_W-1:0] qual_len;
        logic [MODE_W-1:0] mode;
    } lpm_cfg_t;

endpackage

// File: rtl/lpm_cfg_reg.sv
module lpm_cfg_reg
    import lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] rdata_o,
    output lpm_cfg_t         cfg_o
);
    localparam int RESV_W = CFG_W - 1 - QUAL_W - MODE_W;

    lpm_cfg_t cfg_d, cfg_q;
    logic     unused_resv;

    assign unused_resv = ^wdata_i[CFG_W-2 -: RESV_W];

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d.wd_wake_en = wdata_i[CFG_W-1];
            cfg_d.qual_len   = wdata_i[MODE_W +: QUAL_W];
            cfg_d.mode       = wdata_i[MODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o   = cfg_q;
    assign rdata_o = {cfg_q.wd_wake_en, {RESV_W{1'b0}}, cfg_q.qual_len, cfg_q.mode};

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(rdata_o))
        else $error("control word changed without a write");

endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
    parameter int NPIN   = 4,
    parameter int QUAL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic [NPIN-1:0]   pin_n_i,
    input  logic [NPIN-1:0]   sel_i,
    input  logic [QUAL_W-1:0] qual_len_i,
    output logic              qual_hit_o,
    output logic              raw_low_o
);
    localparam int CW = QUAL_W + 1;

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
    } pin_st_t;

    logic [CW-1:0]   limit;
    logic [NPIN-1:0] hit_vec;
    logic [NPIN-1:0] low_vec;

    assign limit = CW'(qual_len_i) + CW'(2);

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        pin_st_t p_d, p_q;

        always_comb begin
            p_d    = p_q;
            p_d.s1 = pin_n_i[g];
            p_d.s2 = p_q.s1;
            if (!active_i || !sel_i[g] || p_q.s2)
                p_d.cnt = '0;
            else if (p_q.cnt < limit)
                p_d.cnt = p_q.cnt + CW'(1);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) p_q <= '{s1: 1'b1, s2: 1'b1, cnt: '0};
            else        p_q <= p_d;
        end

        assign hit_vec[g] = active_i && sel_i[g] && (p_q.cnt >= limit);
        assign low_vec[g] = sel_i[g] && !p_q.s2;
    end

    assign qual_hit_o = |hit_vec;
    assign raw_low_o  = |low_vec;

    p_inactive_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !qual_hit_o)
        else $error("qualification carried over from outside standby");

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lpm_cfg_t   cfg_i,
    input  logic       idle_strobe_i,
    input  logic       irq_any_i,
    input  logic       wd_irq_i,
    input  logic       wd_irq_en_i,
    input  logic       limp_i,
    input  logic       err_clr_i,
    input  logic       stby_hit_i,
    input  logic       halt_low_i,
    input  logic       osc_stable_i,
    input  logic       pll_locked_i,
    output lpm_state_e state_o,
    output logic       cpu_clk_en_o,
    output logic       wake_irq_o,
    output logic       osc_req_o,
    output logic       pll_req_o,
    output logic       halt_err_o
);
    typedef struct packed {
        lpm_state_e st;
        logic       wake;
        logic       err;
    } fsm_t;

    fsm_t s_d, s_q;
    logic wd_ok;

    assign wd_ok = wd_irq_i && cfg_i.wd_wake_en && wd_irq_en_i;

    always_comb begin
        s_d      = s_q;
        s_d.wake = 1'b0;
        if (err_clr_i) s_d.err = 1'b0;
        unique case (s_q.st)
            ST_RUN: begin
                if (idle_strobe_i) begin
                    if (cfg_i.mode == MODE_IDLE) begin
                        s_d.st = ST_IDLE;
                    end else if (cfg_i.mode == MODE_STBY) begin
                        s_d.st = ST_STBY;
                    end else if (limp_i) begin
                        s_d.st  = ST_IDLE;
                        s_d.err = 1'b1;
                    end else begin
                        s_d.st = ST_HOFF;
                    end
                end
            end
            ST_IDLE: begin
                if (irq_any_i) begin
                    s_d.st   = ST_RUN;
                    s_d.wake = 1'b1;
                end
            end
            ST_STBY: begin
                if (stby_hit_i || wd_ok) begin
                    s_d.st   = ST_RUN;
                    s_d.wake = 1'b1;
                end
            end
            ST_HOFF: begin
                if (halt_low_i) s_d.st = ST_HOSC;
            end
            ST_HOSC: begin
                if (!halt_low_i)       s_d.st = ST_HOFF;
                else if (osc_stable_i) s_d.st = ST_HPLL;
            end
            ST_HPLL: begin
                if (pll_locked_i) begin
                    s_d.st   = ST_RUN;
                    s_d.wake = 1'b1;
                end
            end
            default: s_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_RUN, wake: 1'b0, err: 1'b0};
        else        s_q <= s_d;
    end

    assign state_o      = s_q.st;
    assign cpu_clk_en_o = (s_q.st == ST_RUN);
    assign wake_irq_o   = s_q.wake;
    assign halt_err_o   = s_q.err;
    assign osc_req_o    = (s_q.st != ST_HOFF);
    assign pll_req_o    = (s_q.st != ST_HOFF) && (s_q.st != ST_HOSC);

    p_idle_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && irq_any_i) |=> (cpu_clk_en_o && wake_irq_o))
        else $error("idle exit late");

    p_wd_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_STBY && !stby_hit_i && !wd_ok) |=> (s_q.st == ST_STBY))
        else $error("standby left without a wake cause");

    p_pll_after_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_req_o) |-> $past(osc_stable_i))
        else $error("PLL requested before oscillator stable");

    p_limp_fallback_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RUN && idle_strobe_i && cfg_i.mode[1] && limp_i)
            |=> (s_q.st == ST_IDLE && halt_err_o))
        else $error("HALT entered in limp mode");

    p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq_o |=> !wake_irq_o)
        else $error("wake interrupt longer than one cycle");

endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int NPIN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [15:0]     cfg_wdata,
    output logic [15:0]     cfg_rdata,
    input  logic            idle_strobe,
    input  logic            irq_any,
    input  logic            wd_irq,
    input  logic            wd_irq_en,
    input  logic            limp_status,
    input  logic            err_clr,
    input  logic [NPIN-1:0] gpio_wake_n,
    input  logic [NPIN-1:0] gpio_sel,
    input  logic            osc_stable,
    input  logic            pll_locked,
    output logic            osc_pwr_req,
    output logic            pll_lock_req,
    output logic            cpu_clk_en,
    output logic            wake_irq,
    output logic            halt_err,
    output logic [2:0]      lpm_state
);
    lpm_cfg_t   cfg;
    lpm_state_e st;
    logic       stby_hit, halt_low;

    lpm_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .cfg_o   (cfg)
    );

    lpm_wake_qual #(.NPIN(NPIN), .QUAL_W(QUAL_W)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (st == ST_STBY),
        .pin_n_i    (gpio_wake_n),
        .sel_i      (gpio_sel),
        .qual_len_i (cfg.qual_len),
        .qual_hit_o (stby_hit),
        .raw_low_o  (halt_low)
    );

    lpm_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_i         (cfg),
        .idle_strobe_i (idle_strobe),
        .irq_any_i     (irq_any),
        .wd_irq_i      (wd_irq),
        .wd_irq_en_i   (wd_irq_en),
        .limp_i        (limp_status),
        .err_clr_i     (err_clr),
        .stby_hit_i    (stby_hit),
        .halt_low_i    (halt_low),
        .osc_stable_i  (osc_stable),
        .pll_locked_i  (pll_locked),
        .state_o       (st),
        .cpu_clk_en_o  (cpu_clk_en),
        .wake_irq_o    (wake_irq),
        .osc_req_o     (osc_pwr_req),
        .pll_req_o     (pll_lock_req),
        .halt_err_o    (halt_err)
    );

    assign lpm_state = st;

endmodule

// File: tb/lpm_seq_ctrl_tb_top.sv
module lpm_seq_ctrl_tb_top;
    localparam int NPIN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, idle_strobe = 0, irq_any = 0, wd_irq = 0, wd_irq_en = 0;
    logic limp_status = 0, err_clr = 0, osc_stable = 0, pll_locked = 0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [NPIN-1:0] gpio_wake_n = '1;
    logic [NPIN-1:0] gpio_sel = 4'b0001;
    logic osc_pwr_req, pll_lock_req, cpu_clk_en, wake_irq, halt_err;
    logic [2:0] lpm_state;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lpm_seq_ctrl #(.NPIN(NPIN)) dut_i (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int need_low(input int q);
        return q + 2;
    endfunction

    task automatic wr(input logic wd, input int q, input logic [1:0] m);
        cfg_wdata = {wd, 7'd0, 6'(q), m};
        cfg_we = 1;
        step(1);
        cfg_we = 0;
    endtask

    task automatic strobe();
        idle_strobe = 1;
        step(1);
        idle_strobe = 0;
    endtask

    task automatic stby_pulse(input int q, input int len);
        bit woke;
        wr(1'b1, q, 2'b01);
        strobe();
        chk("R3 standby entry", lpm_state, 2);
        gpio_wake_n[0] = 0;
        step(len);
        gpio_wake_n[0] = 1;
        step(need_low(q) + 4);
        woke = (len >= need_low(q));
        chk("R5 qualification", cpu_clk_en, int'(woke));
        if (!woke) begin
            wd_irq = 1;
            step(1);
            wd_irq = 0;
            chk("R7 watchdog wake", cpu_clk_en, 1);
        end
        step(2);
    endtask

    task automatic halt_exit(input logic [1:0] m);
        wr(1'b0, 0, m);
        strobe();
        chk("R3 halt entry", lpm_state, 4);
        chk("R8 osc off", osc_pwr_req, 0);
        chk("R8 pll off", pll_lock_req, 0);
        gpio_wake_n[0] = 0;
        step(3);
        chk("R8 osc phase", lpm_state, 5);
        chk("R8 osc req", osc_pwr_req, 1);
        chk("R8 pll not yet", pll_lock_req, 0);
        gpio_wake_n[0] = 1;
        step(3);
        chk("R9 abort to off", lpm_state, 4);
        gpio_wake_n[0] = 0;
        step(3);
        chk("R9 restart", lpm_state, 5);
        osc_stable = 1;
        step(1);
        chk("R8 pll phase", lpm_state, 6);
        chk("R8 pll req", pll_lock_req, 1);
        pll_locked = 1;
        step(1);
        chk("R8 run", cpu_clk_en, 1);
        chk("R11 halt wake pulse", wake_irq, 1);
        osc_stable = 0;
        pll_locked = 0;
        gpio_wake_n[0] = 1;
        step(1);
        chk("R11 pulse ends", wake_irq, 0);
        step(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        step(3);
        chk("R1 rdata", cfg_rdata, 0);
        chk("R1 state", lpm_state, 0);
        rst_n = 1;
        step(1);
        chk("R1 clk_en", cpu_clk_en, 1);
        chk("R1 osc", osc_pwr_req, 1);
        chk("R1 pll", pll_lock_req, 1);
        chk("R1 wake", wake_irq, 0);
        chk("R1 err", halt_err, 0);

        cfg_wdata = 16'hFFFF; cfg_we = 1; step(1); cfg_we = 0;
        chk("R2 reserved zero", cfg_rdata, 16'h80FF);
        chk("R3 write no effect", cpu_clk_en, 1);
        step(4);
        chk("R3 still run", lpm_state, 0);
        chk("R11 no stray pulse", wake_irq, 0);

        wr(1'b0, 0, 2'b00);
        strobe();
        chk("R3 idle entry", lpm_state, 1);
        chk("R4 gated", cpu_clk_en, 0);
        wd_irq = 1; step(2); wd_irq = 0;
        chk("R4 stays idle", lpm_state, 1);
        irq_any = 1; step(1); irq_any = 0;
        chk("R4 clock open", cpu_clk_en, 1);
        chk("R11 idle pulse", wake_irq, 1);
        step(1);
        chk("R11 one cycle", wake_irq, 0);

        wr(1'b1, 3, 2'b01);
        strobe();
        gpio_wake_n[0] = 0;
        step(need_low(3) + 2);
        chk("R5 not yet", cpu_clk_en, 0);
        step(1);
        chk("R5 wake", cpu_clk_en, 1);
        chk("R11 stby pulse", wake_irq, 1);
        gpio_wake_n[0] = 1;
        step(3);

        wr(1'b1, 0, 2'b01);
        strobe();
        gpio_wake_n[1] = 0;
        step(20);
        chk("R6 unselected ignored", lpm_state, 2);
        gpio_wake_n[1] = 1;
        wd_irq = 1; wd_irq_en = 0; step(3);
        chk("R7 half enabled", lpm_state, 2);
        wd_irq_en = 1; step(1); wd_irq = 0;
        chk("R7 both enabled", cpu_clk_en, 1);
        step(2);
        wr(1'b0, 0, 2'b01);
        strobe();
        wd_irq = 1; step(3); wd_irq = 0;
        chk("R7 wake bit clear", lpm_state, 2);
        wr(1'b1, 0, 2'b01);
        wd_irq = 1; step(1); wd_irq = 0;
        step(2);

        gpio_wake_n[0] = 0; step(10); gpio_wake_n[0] = 1; step(3);
        wr(1'b1, 5, 2'b01);
        strobe();
        step(4);
        chk("R6 run lows not counted", lpm_state, 2);
        wd_irq = 1; step(1); wd_irq = 0; step(2);

        stby_pulse(0, 1);
        stby_pulse(0, 2);
        stby_pulse(63, 64);
        stby_pulse(63, 65);
        for (int i = 0; i < 10; i++) begin
            int q, len;
            q = $urandom % 10;
            len = 1 + ($urandom % (need_low(q) + 3));
            stby_pulse(q, len);
        end

        halt_exit(2'b10);
        halt_exit(2'b11);

        limp_status = 1;
        wr(1'b0, 0, 2'b10);
        strobe();
        chk("R10 idle fallback", lpm_state, 1);
        chk("R10 err set", halt_err, 1);
        irq_any = 1; step(1); irq_any = 0;
        step(3);
        chk("R10 sticky", halt_err, 1);
        err_clr = 1; step(1); err_clr = 0;
        chk("R10 cleared", halt_err, 0);
        limp_status = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule